// File: doc/BRIEF.md
# Floppy Drive Control and Status Register Block

This block is the host-facing drive control register of a floppy disk controller, together with two read-only status registers. A byte written to the control register picks one of four drives, switches the four spindle motors on or off, holds the controller core in soft reset, and gates the DMA and interrupt pins. The drive-select outputs follow the decoded drive number only while that drive's motor bit is set.

The status registers have three views, chosen by `view_sel`:

- **Compatible view (00):** reads of the status offsets leave the bus undriven.
- **Live view (01):** the status registers show the synchronized drive-side pin levels, plus toggle bits for read and write data.
- **Latched view (10):** edge events are held until the host reads the digital input register. That read arrives here as a one-cycle strobe, `dir_rd_stb`.

The code 11 behaves as the compatible view.

A two-state machine tracks the core reset:

| State | Meaning | Entered by |
|---|---|---|
| `CORE_HELD` | Core held in reset | Hardware reset; a control write with bit 2 = 0 while in `CORE_RUN` (transition `RELEASE_TO_HOLD`) |
| `CORE_RUN` | Core running | A control write with bit 2 = 1 while in `CORE_HELD` (transition `HOLD_TO_RUN`) |

Any other write leaves the state as it is. All ten drive-side inputs pass through a two-flop synchronizer before they are read as levels, edges or toggles.

Top module: `fdd_ctrl_status`

## Requirements
- R1: Hardware reset (rst_n low) clears the control register to 00h. Reads at offset 2 return the last byte written there, with reg_rdata_oe high.
- R2: Each motor output mot_n[i] is the inverse of control bit 4+i, for i in 0..3.
- R3: ds_n[i] is low only when control bits 1:0 equal i and motor bit 4+i is set; at most one ds_n bit is low. Writes of 1Ch, 2Dh, 4Eh and 8Fh select and spin drives 0, 1, 2 and 3.
- R4: After a control write, core_rst is high when bit 2 was 0 and low when it was 1. The state machine starts in CORE_HELD, and soft reset does not change the stored control byte.
- R5: In views other than 01, control bit 3 = 0 drives drq_oe and intr_oe low, forces core_dack_n high and forces core_tc low. Bit 3 = 1 passes dack_n and tc through and enables both outputs.
- R6: In view 01, drq_oe and intr_oe are high and dack_n and tc pass through whatever bit 3 holds.
- R7: In view 00, reads of offset 0 (status A) and offset 1 (status B) keep reg_rdata_oe low.
- R8: In view 01, status A reads {core_intr, ~drv2, step, ~trk0, hdsel, ~index, ~wp, dir}, from bit 7 down to bit 0.
- R9: In view 10, status A reads {core_intr, core_drq, step latch, trk0, ~hdsel, index, wp, ~dir}. The step latch sets on a rising step. It clears the cycle after dir_rd_stb, and also while core_rst is high.
- R10: In view 01, status B reads {1, 1, control bit 0, write-data toggle, read-data toggle, wgate, control bit 5, control bit 4}. Each toggle flips on every falling edge of its data input.
- R11: In view 10, status B reads {~drv2, ds_n[1], ds_n[0], write-data latch, read-data latch, write-gate latch, ds_n[3], ds_n[2]}. Write gate latches on its rising edge; read and write data latch on their falling edges, with write data not gated by write gate. All three latches clear the cycle after dir_rd_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| reg_addr | input | 3 | Register offset: 0 status A, 1 status B, 2 control |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| reg_rdata_oe | output | 1 | Read data bus drive enable |
| view_sel | input | 2 | Status view: 00 compatible, 01 live, 10 latched |
| dir_rd_stb | input | 1 | One-cycle digital input register read strobe |
| pin_step | input | 1 | Step output level, high = active |
| pin_dir | input | 1 | Head direction, high = inward |
| pin_hdsel | input | 1 | Head select, high = side 1 |
| pin_index | input | 1 | Index, high = active |
| pin_trk0 | input | 1 | Track 0, high = active |
| pin_wp | input | 1 | Write protect, high = active |
| pin_drv2 | input | 1 | Second drive present, high = present |
| pin_rdata | input | 1 | Read data pulse, high = active |
| pin_wdata | input | 1 | Write data pulse, high = active |
| pin_wgate | input | 1 | Write gate, high = active |
| core_intr | input | 1 | Interrupt from the controller core |
| core_drq | input | 1 | DMA request from the controller core |
| dack_n | input | 1 | DMA acknowledge from the bus, active low |
| tc | input | 1 | Terminal count from the bus |
| core_dack_n | output | 1 | Gated DMA acknowledge to the core |
| core_tc | output | 1 | Gated terminal count to the core |
| intr_out | output | 1 | Interrupt pin value |
| intr_oe | output | 1 | Interrupt pin drive enable |
| drq_out | output | 1 | DMA request pin value |
| drq_oe | output | 1 | DMA request pin drive enable |
| core_rst | output | 1 | Soft reset to the controller core |
| ds_n | output | 4 | Drive selects, active low |
| mot_n | output | 4 | Motor enables, active low |

## Verification
A wrong control byte shows at ds_n, mot_n or the offset-2 readback on the cycle after the write. A stuck state machine shows the same way, through core_rst and the DMA pin enables. A wrong synchronizer, edge detector, toggle or latch appears at the status readback within four clocks of a pin change, or on the cycle after a strobe. The bench therefore applies each stimulus, waits that bound, and reads the status registers in every view. It also drives edges of the wrong polarity and checks that the latches stay clear.

// File: rtl/fdd_regs_pkg.sv
package fdd_regs_pkg;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int NDRV  = 4;
    localparam int SELW  = $clog2(NDRV);
    localparam int NPIN  = 10;

    localparam logic [AW-1:0] OFS_STA = 3'd0;
    localparam logic [AW-1:0] OFS_STB = 3'd1;
    localparam logic [AW-1:0] OFS_CTL = 3'd2;

    localparam logic [1:0] VIEW_COMPAT = 2'b00;
    localparam logic [1:0] VIEW_LIVE   = 2'b01;
    localparam logic [1:0] VIEW_LATCH  = 2'b10;

    // synchronized pin vector positions
    localparam int PI_STEP  = 0;
    localparam int PI_DIR   = 1;
    localparam int PI_HDSEL = 2;
    localparam int PI_INDEX = 3;
    localparam int PI_TRK0  = 4;
    localparam int PI_WP    = 5;
    localparam int PI_DRV2  = 6;
    localparam int PI_RDATA = 7;
    localparam int PI_WDATA = 8;
    localparam int PI_WGATE = 9;

    // event latch vector positions
    localparam int NLAT   = 4;
    localparam int LA_STEP = 0;
    localparam int LA_WG   = 1;
    localparam int LA_RD   = 2;
    localparam int LA_WD   = 3;

    typedef enum logic {CORE_HELD = 1'b0, CORE_RUN = 1'b1} core_st_t;
endpackage

// File: rtl/fdd_sync_bank.sv
module fdd_sync_bank #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dsync,
    output logic [W-1:0] dprev
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
            dprev <= '0;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
            dprev <= stg[STAGES-1];
        end
    end

    assign dsync = stg[STAGES-1];
endmodule

// File: rtl/fdd_drive_decode.sv
module fdd_drive_decode
    import fdd_regs_pkg::*;
(
    input  logic [SELW-1:0] drv_sel,
    input  logic [NDRV-1:0] mot_en,
    output logic [NDRV-1:0] ds_n,
    output logic [NDRV-1:0] mot_n
);
    for (genvar i = 0; i < NDRV; i++) begin : g_drv
        assign ds_n[i]  = !((drv_sel == SELW'(i)) && mot_en[i]);
        assign mot_n[i] = !mot_en[i];
    end
endmodule

// File: rtl/fdd_event_latch.sv
module fdd_event_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    // a set in the same cycle as a clear wins, so no edge is lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= set | (q & ~clr);
    end
endmodule

// File: rtl/fdd_ctrl_status.sv
module fdd_ctrl_status
    import fdd_regs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          reg_rdata_oe,
    input  logic [1:0]    view_sel,
    input  logic          dir_rd_stb,
    input  logic          pin_step,
    input  logic          pin_dir,
    input  logic          pin_hdsel,
    input  logic          pin_index,
    input  logic          pin_trk0,
    input  logic          pin_wp,
    input  logic          pin_drv2,
    input  logic          pin_rdata,
    input  logic          pin_wdata,
    input  logic          pin_wgate,
    input  logic          core_intr,
    input  logic          core_drq,
    input  logic          dack_n,
    input  logic          tc,
    output logic          core_dack_n,
    output logic          core_tc,
    output logic          intr_out,
    output logic          intr_oe,
    output logic          drq_out,
    output logic          drq_oe,
    output logic          core_rst,
    output logic [NDRV-1:0] ds_n,
    output logic [NDRV-1:0] mot_n
);
    logic [DW-1:0] ctl_q;
    core_st_t      st_q, st_d;
    logic          ctl_wr;

    assign ctl_wr = reg_wr && (reg_addr == OFS_CTL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= reg_wdata;
    end

    // soft reset state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CORE_HELD;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            unique case (st_q)
                CORE_HELD: if (reg_wdata[2])  st_d = CORE_RUN;
                CORE_RUN:  if (!reg_wdata[2]) st_d = CORE_HELD;
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        unique case (st_q)
            CORE_HELD: core_rst = 1'b1;
            CORE_RUN:  core_rst = 1'b0;
        endcase
    end

    fdd_drive_decode i_decode (
        .drv_sel (ctl_q[SELW-1:0]),
        .mot_en  (ctl_q[7:4]),
        .ds_n    (ds_n),
        .mot_n   (mot_n)
    );

    logic [NPIN-1:0] pin_raw, pin_s, pin_p, rise, fall;
    assign pin_raw = {pin_wgate, pin_wdata, pin_rdata, pin_drv2, pin_wp,
                      pin_trk0, pin_index, pin_hdsel, pin_dir, pin_step};

    fdd_sync_bank #(.W(NPIN), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_raw),
        .dsync (pin_s),
        .dprev (pin_p)
    );

    assign rise = pin_s & ~pin_p;
    assign fall = ~pin_s & pin_p;

    logic rd_tog, wd_tog;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_tog <= 1'b0;
            wd_tog <= 1'b0;
        end else begin
            if (fall[PI_RDATA]) rd_tog <= !rd_tog;
            if (fall[PI_WDATA]) wd_tog <= !wd_tog;
        end
    end

    logic [NLAT-1:0] lat_set, lat_clr, lat_q;
    always_comb begin
        lat_set          = '0;
        lat_set[LA_STEP] = rise[PI_STEP];
        lat_set[LA_WG]   = rise[PI_WGATE];
        lat_set[LA_RD]   = fall[PI_RDATA];
        lat_set[LA_WD]   = fall[PI_WDATA];
        lat_clr          = {NLAT{dir_rd_stb}};
        lat_clr[LA_STEP] = dir_rd_stb || core_rst;
    end

    fdd_event_latch #(.W(NLAT)) i_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (lat_set),
        .clr   (lat_clr),
        .q     (lat_q)
    );

    logic dma_en;
    assign dma_en      = ctl_q[3] || (view_sel == VIEW_LIVE);
    assign core_dack_n = dma_en ? dack_n : 1'b1;
    assign core_tc     = dma_en ? tc : 1'b0;
    assign intr_out    = core_intr;
    assign drq_out     = core_drq;
    assign intr_oe     = dma_en;
    assign drq_oe      = dma_en;

    logic [DW-1:0] sta_live, sta_lat, stb_live, stb_lat;
    assign sta_live = {core_intr, !pin_s[PI_DRV2], pin_s[PI_STEP], !pin_s[PI_TRK0],
                       pin_s[PI_HDSEL], !pin_s[PI_INDEX], !pin_s[PI_WP], pin_s[PI_DIR]};
    assign sta_lat  = {core_intr, core_drq, lat_q[LA_STEP], pin_s[PI_TRK0],
                       !pin_s[PI_HDSEL], pin_s[PI_INDEX], pin_s[PI_WP], !pin_s[PI_DIR]};
    assign stb_live = {2'b11, ctl_q[0], wd_tog, rd_tog, pin_s[PI_WGATE], ctl_q[5], ctl_q[4]};
    assign stb_lat  = {!pin_s[PI_DRV2], ds_n[1], ds_n[0], lat_q[LA_WD], lat_q[LA_RD],
                       lat_q[LA_WG], ds_n[3], ds_n[2]};

    always_comb begin
        reg_rdata    = '0;
        reg_rdata_oe = 1'b0;
        if (reg_rd) begin
            case (reg_addr)
                OFS_CTL: begin
                    reg_rdata    = ctl_q;
                    reg_rdata_oe = 1'b1;
                end
                OFS_STA: begin
                    if (view_sel == VIEW_LIVE) begin
                        reg_rdata = sta_live; reg_rdata_oe = 1'b1;
                    end else if (view_sel == VIEW_LATCH) begin
                        reg_rdata = sta_lat;  reg_rdata_oe = 1'b1;
                    end
                end
                OFS_STB: begin
                    if (view_sel == VIEW_LIVE) begin
                        reg_rdata = stb_live; reg_rdata_oe = 1'b1;
                    end else if (view_sel == VIEW_LATCH) begin
                        reg_rdata = stb_lat;  reg_rdata_oe = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    AST_CTL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(ctl_q)); // R1
    AST_MOTOR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (mot_n == ~$past(reg_wdata[7:4]))); // R2
    AST_DS_NEEDS_MOTOR: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ds_n) & mot_n) == '0); // R3
    AST_ONE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ds_n) <= 1); // R3
    AST_SOFT_RESET_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (core_rst == !$past(reg_wdata[2]))); // R4
    AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((view_sel != VIEW_LIVE) && !ctl_q[3]) |-> (!drq_oe && !intr_oe && core_dack_n && !core_tc)); // R5
    AST_LIVE_ALWAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (view_sel == VIEW_LIVE) |-> (drq_oe && intr_oe)); // R6
    AST_COMPAT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        ((view_sel == VIEW_COMPAT) && reg_rd && (reg_addr == OFS_STA || reg_addr == OFS_STB))
        |-> !reg_rdata_oe); // R7
    AST_STEP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_rd_stb && !rise[PI_STEP]) |=> !lat_q[LA_STEP]); // R9
    AST_RD_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall[PI_RDATA] |=> (rd_tog != $past(rd_tog))); // R10
    AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_rd_stb && !fall[PI_WDATA] && !fall[PI_RDATA] && !rise[PI_WGATE])
        |=> (lat_q[LA_WD] == 1'b0 && lat_q[LA_RD] == 1'b0 && lat_q[LA_WG] == 1'b0)); // R11
endmodule

// File: tb/test_fdd_ctrl_status.sv
module test_fdd_ctrl_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic reg_rdata_oe;
    logic [1:0] view_sel = 2'b00;
    logic dir_rd_stb = 0;
    logic pin_step = 0, pin_dir = 0, pin_hdsel = 0, pin_index = 0, pin_trk0 = 0;
    logic pin_wp = 0, pin_drv2 = 0, pin_rdata = 0, pin_wdata = 0, pin_wgate = 0;
    logic core_intr = 0, core_drq = 0, dack_n = 1, tc = 0;
    logic core_dack_n, core_tc, intr_out, intr_oe, drq_out, drq_oe, core_rst;
    logic [3:0] ds_n, mot_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fdd_ctrl_status i_fdd_ctrl_status (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rdata_oe(reg_rdata_oe),
        .view_sel(view_sel), .dir_rd_stb(dir_rd_stb),
        .pin_step(pin_step), .pin_dir(pin_dir), .pin_hdsel(pin_hdsel), .pin_index(pin_index),
        .pin_trk0(pin_trk0), .pin_wp(pin_wp), .pin_drv2(pin_drv2), .pin_rdata(pin_rdata),
        .pin_wdata(pin_wdata), .pin_wgate(pin_wgate), .core_intr(core_intr), .core_drq(core_drq),
        .dack_n(dack_n), .tc(tc), .core_dack_n(core_dack_n), .core_tc(core_tc),
        .intr_out(intr_out), .intr_oe(intr_oe), .drq_out(drq_out), .drq_oe(drq_oe),
        .core_rst(core_rst), .ds_n(ds_n), .mot_n(mot_n)
    );

    // {write byte, expected ds_n, expected mot_n}
    localparam logic [15:0] VEC [8] = '{
        {8'h1C, 4'b1110, 4'b1110},
        {8'h2D, 4'b1101, 4'b1101},
        {8'h4E, 4'b1011, 4'b1011},
        {8'h8F, 4'b0111, 4'b0111},
        {8'h0F, 4'b1111, 4'b1111},
        {8'hF0, 4'b1110, 4'b0000},
        {8'h3D, 4'b1101, 4'b1100},
        {8'h17, 4'b1111, 4'b1110}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk);
        reg_addr = 3'd2; reg_wdata = v; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        reg_addr = a; reg_rd = 1;
        #1;
        d = reg_rdata; oe = reg_rdata_oe;
        reg_rd = 0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic strobe_dir();
        @(negedge clk);
        dir_rd_stb = 1;
        @(negedge clk);
        dir_rd_stb = 0;
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic oe;
        repeat (3) @(negedge clk);
        // R1 R4 reset state
        rd_reg(3'd2, d, oe);
        check("R1 reset ctl", {oe, d}, {1'b1, 8'h00});
        check("R1 reset ds/mot", {ds_n, mot_n}, 8'hFF);
        check("R4 reset held", core_rst, 1);
        rst_n = 1;
        @(negedge clk);
        check("R4 held after reset", core_rst, 1);

        for (int i = 0; i < 8; i++) begin
            wr_ctl(VEC[i][15:8]);
            check("R3 drive select", ds_n, VEC[i][7:4]);
            check("R2 motor", mot_n, VEC[i][3:0]);
            rd_reg(3'd2, d, oe);
            check("R1 readback", d, VEC[i][15:8]);
        end

        // R4 soft reset
        wr_ctl(8'h8F);
        check("R4 run", core_rst, 0);
        wr_ctl(8'h8B);
        check("R4 held", core_rst, 1);
        rd_reg(3'd2, d, oe);
        check("R4 ctl preserved", d, 8'h8B);
        check("R4 motor kept", mot_n, 4'b0111);

        // R5 R6 DMA gating
        dack_n = 0; tc = 1; core_drq = 1; core_intr = 1;
        view_sel = 2'b00;
        wr_ctl(8'h04);
        check("R5 gated", {drq_oe, intr_oe, core_dack_n, core_tc}, 4'b0010);
        wr_ctl(8'h0C);
        check("R5 enabled", {drq_oe, intr_oe, core_dack_n, core_tc, drq_out, intr_out}, 6'b110111);
        wr_ctl(8'h04);
        view_sel = 2'b01;
        #1;
        check("R6 live on", {drq_oe, intr_oe, core_dack_n, core_tc}, 4'b1101);
        view_sel = 2'b10;
        #1;
        check("R5 latched gated", {drq_oe, intr_oe, core_dack_n, core_tc}, 4'b0010);
        dack_n = 1; tc = 0; core_drq = 0;

        // R7 compatible view floats status
        view_sel = 2'b00;
        rd_reg(3'd0, d, oe);
        check("R7 status A float", oe, 0);
        rd_reg(3'd1, d, oe);
        check("R7 status B float", oe, 0);
        rd_reg(3'd2, d, oe);
        check("R7 ctl driven", oe, 1);

        // R8 live status A
        wr_ctl(8'h0C);
        view_sel = 2'b01;
        core_intr = 1; pin_drv2 = 1; pin_step = 0; pin_trk0 = 1; pin_hdsel = 1;
        pin_index = 0; pin_wp = 1; pin_dir = 1;
        settle();
        rd_reg(3'd0, d, oe);
        check("R8 status A live 1", {oe, d}, {1'b1, 8'h8D});
        core_intr = 0; pin_drv2 = 0; pin_step = 1; pin_trk0 = 0; pin_hdsel = 0;
        pin_index = 1; pin_wp = 0; pin_dir = 0;
        settle();
        rd_reg(3'd0, d, oe);
        check("R8 status A live 2", d, 8'h72);

        // R10 live status B and toggles
        wr_ctl(8'h1D);
        rd_reg(3'd1, d, oe);
        check("R10 status B base", {oe, d}, {1'b1, 8'hE1});
        pin_rdata = 1; settle(); pin_rdata = 0; settle();
        rd_reg(3'd1, d, oe);
        check("R10 read toggle", d, 8'hE9);
        pin_wdata = 1; settle(); pin_wdata = 0; settle();
        rd_reg(3'd1, d, oe);
        check("R10 write toggle", d, 8'hF9);
        pin_wgate = 1; settle();
        rd_reg(3'd1, d, oe);
        check("R10 wgate live", d, 8'hFD);
        pin_rdata = 1; settle(); pin_rdata = 0; settle();
        rd_reg(3'd1, d, oe);
        check("R10 read toggle back", d, 8'hF5);
        pin_wgate = 0; settle();

        // R9 latched status A
        view_sel = 2'b10;
        core_drq = 1;
        strobe_dir();
        pin_step = 0; settle();
        rd_reg(3'd0, d, oe);
        check("R9 status A latched clear", {oe, d}, {1'b1, 8'h4D});
        pin_step = 1; settle(); pin_step = 0; settle();
        rd_reg(3'd0, d, oe);
        check("R9 step latched", d, 8'h6D);
        strobe_dir();
        rd_reg(3'd0, d, oe);
        check("R9 cleared by strobe", d, 8'h4D);
        pin_step = 1; settle(); pin_step = 0; settle();
        wr_ctl(8'h19);
        wr_ctl(8'h1D);
        rd_reg(3'd0, d, oe);
        check("R9 cleared by soft reset", d, 8'h4D);

        // R11 latched status B
        wr_ctl(8'h2D);
        rd_reg(3'd1, d, oe);
        check("R11 status B base", {oe, d}, {1'b1, 8'hA3});
        pin_wdata = 1; settle(); pin_wdata = 0; settle();
        rd_reg(3'd1, d, oe);
        check("R11 write data latch", d, 8'hB3);
        pin_rdata = 1; settle(); pin_rdata = 0; settle();
        rd_reg(3'd1, d, oe);
        check("R11 read data latch", d, 8'hBB);
        pin_wgate = 1; settle();
        rd_reg(3'd1, d, oe);
        check("R11 write gate latch", d, 8'hBF);
        strobe_dir();
        rd_reg(3'd1, d, oe);
        check("R11 cleared by strobe", d, 8'hA3);
        pin_rdata = 1; settle();
        rd_reg(3'd1, d, oe);
        check("R11 rising read data ignored", d, 8'hA3);
        pin_rdata = 0; settle();
        rd_reg(3'd1, d, oe);
        check("R11 falling read data latched", d, 8'hAB);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule